// File: doc/BRIEF.md
# Enable-Gated Down-Counting Watchdog

This block is a 32-bit down-counting watchdog on a simple register bus. Every access takes one cycle. Software writes a load value. It then sets the interrupt-enable bit in the control register, and that bit starts the counter. Each single-cycle pulse on the tick input then moves the count down by one. When the count reaches zero, a raw interrupt flag is set. The count reloads from the load value on the next tick. If the count reaches zero a second time while the flag is still set, and reset generation is enabled, a sticky reset request is raised. Writing the interrupt-clear register clears the flag and restarts the count. The interrupt-enable bit is the run/stop control: clearing it freezes the count, and setting it again from zero reloads the count.

The interrupt and reset behaviour is held in a four-state alarm machine:

- QUIET: no flag.
- RAISED: flag set.
- TRIP_QUIET: reset requested, flag cleared.
- TRIP_RAISED: reset requested, flag set.

Its transitions are:

- QUIET to RAISED on a zero hit.
- RAISED to QUIET on a clear.
- RAISED to TRIP_RAISED on a zero hit with reset generation enabled.
- TRIP_RAISED to TRIP_QUIET on a clear.
- TRIP_QUIET to TRIP_RAISED on a zero hit.

Only block reset leaves the two TRIP states. The parameter LOCK_CTRL selects a variant in which the control register ignores writes once interrupt-enable is set.

Top module: `wdog_timer`

## Requirements
- R1: After reset, load and value read 0xFFFFFFFF, control, raw status and masked status read 0, irq and rst_req are low, and ticks do not change the value.
- R2: Byte offsets are load 0x00, value 0x04 (read-only), control 0x08, interrupt clear 0x0C (write-only, reads 0), raw status 0x10 (bit 0), masked status 0x14 (bit 0). Control keeps only bit 0 (interrupt enable) and bit 1 (reset enable). Unused bits and unmapped offsets read 0, and writes to them and to read-only offsets change nothing.
- R3: With interrupt enable at 1, each tick decrements the value. With it at 0, the value stays frozen.
- R4: A control write that changes interrupt enable from 0 to 1 reloads the value from load. A control write that leaves it at 1 does not reload.
- R5: A load write sets the value to the written data at the next cycle, whether the counter runs or not, and does not start the counter.
- R6: A running tick taking the value to zero sets raw status. A tick from value zero reloads the value from load.
- R7: A write of any data to offset 0x0C clears raw status and reloads the value from load.
- R8: irq is high exactly when raw status and interrupt enable are both 1. Offset 0x14 returns that value.
- R9: A zero hit while raw status is already 1 and reset enable is 1 raises rst_req, which stays high until block reset.
- R10: With LOCK_CTRL=1, control writes are ignored while interrupt enable is 1, so control keeps reading its bit 0 as 1.
- R11: A bus write in a cycle with a tick suppresses that tick's decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Single-cycle count pulse |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr, combinational |
| irq | output | 1 | Masked interrupt |
| rst_req | output | 1 | Sticky reset request |

## Verification
The bench builds two copies side by side and drives the same stimulus into both. One copy has LOCK_CTRL=0 and the other LOCK_CTRL=1. The unlocked copy reaches the freeze, re-enable reload and unchanged-enable paths. The locked copy shows the same writes being refused once counting has started, and then diverges in value, status and reset request. Ticks are applied both on every cycle and on every third cycle, so writes land both on tick cycles and between them.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned OFS_LOAD  = 'h00;
    localparam int unsigned OFS_VALUE = 'h04;
    localparam int unsigned OFS_CTRL  = 'h08;
    localparam int unsigned OFS_ICLR  = 'h0C;
    localparam int unsigned OFS_RAW   = 'h10;
    localparam int unsigned OFS_MASK  = 'h14;

    typedef enum logic [1:0] {
        ALM_QUIET       = 2'd0,
        ALM_RAISED      = 2'd1,
        ALM_TRIP_QUIET  = 2'd2,
        ALM_TRIP_RAISED = 2'd3
    } alarm_state_t;

    typedef struct packed {
        logic wr_load;
        logic wr_ctrl;
        logic wr_iclr;
    } wr_strobe_t;
endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter bit LOCK_CTRL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] load_q,
    output logic              inten_q,
    output logic              resen_q,
    output wr_strobe_t        strobe,
    output logic              en_rise
);
    logic ctrl_wr_ok;

    always_comb begin
        strobe.wr_load = wr_en && (addr == ADDR_W'(OFS_LOAD));
        strobe.wr_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
        strobe.wr_iclr = wr_en && (addr == ADDR_W'(OFS_ICLR));
    end

    generate
        if (LOCK_CTRL) begin : g_locked
            assign ctrl_wr_ok = strobe.wr_ctrl && !inten_q;
        end else begin : g_open
            assign ctrl_wr_ok = strobe.wr_ctrl;
        end
    endgenerate

    assign en_rise = ctrl_wr_ok && !inten_q && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q  <= '1;
            inten_q <= 1'b0;
            resen_q <= 1'b0;
        end else begin
            if (strobe.wr_load) begin
                load_q <= wdata;
            end
            if (ctrl_wr_ok) begin
                inten_q <= wdata[0];
                resen_q <= wdata[1];
            end
        end
    end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_from_wdata,
    input  logic              reload,
    input  logic              run_tick,
    output logic [DATA_W-1:0] cnt_q,
    output logic              hit_zero
);
    logic [DATA_W-1:0] nxt;

    always_comb begin
        nxt      = (cnt_q == '0) ? load_val : cnt_q - 1'b1;
        hit_zero = run_tick && (nxt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (set_from_wdata) begin
            cnt_q <= wdata;
        end else if (reload) begin
            cnt_q <= load_val;
        end else if (run_tick) begin
            cnt_q <= nxt;
        end
    end
endmodule

// File: rtl/wdt_alarm_fsm.sv
module wdt_alarm_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_zero,
    input  logic clr,
    input  logic resen,
    output logic raw,
    output logic rst_req
);
    alarm_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ALM_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_QUIET: begin
                if (hit_zero) state_d = ALM_RAISED;
            end
            ALM_RAISED: begin
                if (clr)                    state_d = ALM_QUIET;
                else if (hit_zero && resen) state_d = ALM_TRIP_RAISED;
            end
            ALM_TRIP_QUIET: begin
                if (hit_zero) state_d = ALM_TRIP_RAISED;
            end
            ALM_TRIP_RAISED: begin
                if (clr) state_d = ALM_TRIP_QUIET;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ALM_QUIET:       begin raw = 1'b0; rst_req = 1'b0; end
            ALM_RAISED:      begin raw = 1'b1; rst_req = 1'b0; end
            ALM_TRIP_QUIET:  begin raw = 1'b0; rst_req = 1'b1; end
            ALM_TRIP_RAISED: begin raw = 1'b1; rst_req = 1'b1; end
        endcase
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter bit LOCK_CTRL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              rst_req
);
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] cnt_q;
    logic              inten;
    logic              resen;
    logic              en_rise;
    logic              hit_zero;
    logic              raw;
    logic              run_tick;
    wr_strobe_t        strobe;

    wdt_ctrl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_CTRL(LOCK_CTRL)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .load_q  (load_q),
        .inten_q (inten),
        .resen_q (resen),
        .strobe  (strobe),
        .en_rise (en_rise)
    );

    assign run_tick = tick_en && !wr_en && inten;

    wdt_down_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_val       (load_q),
        .wdata          (wdata),
        .set_from_wdata (strobe.wr_load),
        .reload         (en_rise || strobe.wr_iclr),
        .run_tick       (run_tick),
        .cnt_q          (cnt_q),
        .hit_zero       (hit_zero)
    );

    wdt_alarm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_zero (hit_zero),
        .clr      (strobe.wr_iclr),
        .resen    (resen),
        .raw      (raw),
        .rst_req  (rst_req)
    );

    assign irq = raw && inten;

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_LOAD))       rdata = load_q;
        else if (addr == ADDR_W'(OFS_VALUE)) rdata = cnt_q;
        else if (addr == ADDR_W'(OFS_CTRL))  rdata = DATA_W'({resen, inten});
        else if (addr == ADDR_W'(OFS_RAW))   rdata = DATA_W'(raw);
        else if (addr == ADDR_W'(OFS_MASK))  rdata = DATA_W'(irq);
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter bit LOCK_CTRL = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic              rst_req,
    input logic              inten,
    input logic              raw,
    input logic [DATA_W-1:0] cnt
);
    assert_sticky_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!inten && !wr_en) |=> $stable(cnt));

    assert_clear_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_ICLR)) |=> !raw);

    assert_lock_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (LOCK_CTRL && inten) |=> inten);

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> inten);

    assert_load_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_LOAD)) |=> (cnt == $past(wdata)));

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_RAW)) |=> $stable(cnt));
endmodule

bind wdog_timer wdt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_CTRL(LOCK_CTRL)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq     (irq),
    .rst_req (rst_req),
    .inten   (inten),
    .raw     (raw),
    .cnt     (cnt_q)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;
    localparam int DW = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd0, rd1;
    logic          irq0, irq1, rq0, rq1;

    int    checks = 0;
    int    bad = 0;
    int    cyc_n = 0;
    int    tick_every = 1;
    bit    done = 1'b0;
    string phase = "R1";

    // model state: index 0 unlocked, 1 locked
    logic [31:0] m_load[2];
    logic [31:0] m_cnt[2];
    logic [1:0]  m_ctrl[2];
    bit          m_raw[2];
    bit          m_rst[2];

    always #10 clk = ~clk;

    wdog_timer #(.DATA_W(DW), .ADDR_W(AW), .LOCK_CTRL(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rd0), .irq(irq0), .rst_req(rq0));

    wdog_timer #(.DATA_W(DW), .ADDR_W(AW), .LOCK_CTRL(1'b1)) dut_lock (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rd1), .irq(irq1), .rst_req(rq1));

    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            if (!rst_n) begin
                m_load[v] = 32'hFFFF_FFFF; m_cnt[v] = 32'hFFFF_FFFF;
                m_ctrl[v] = 2'b00; m_raw[v] = 0; m_rst[v] = 0;
            end else if (wr_en) begin
                // R11: any write suppresses the tick
                if (addr == 8'h00) begin
                    m_load[v] = wdata; m_cnt[v] = wdata;
                end else if (addr == 8'h08) begin
                    if (!(v == 1 && m_ctrl[v][0])) begin
                        if (!m_ctrl[v][0] && wdata[0]) m_cnt[v] = m_load[v];
                        m_ctrl[v] = wdata[1:0];
                    end
                end else if (addr == 8'h0C) begin
                    m_raw[v] = 0; m_cnt[v] = m_load[v];
                end
            end else if (tick_en && m_ctrl[v][0]) begin
                logic [31:0] n;
                n = (m_cnt[v] == 0) ? m_load[v] : m_cnt[v] - 1;
                if (n == 0) begin
                    if (m_raw[v] && m_ctrl[v][1]) m_rst[v] = 1;
                    m_raw[v] = 1;
                end
                m_cnt[v] = n;
            end
        end
    end

    function automatic logic [31:0] m_rd(int v, logic [7:0] a);
        case (a)
            8'h00: return m_load[v];
            8'h04: return m_cnt[v];
            8'h08: return {30'b0, m_ctrl[v]};
            8'h10: return {31'b0, m_raw[v]};
            8'h14: return {31'b0, m_raw[v] & m_ctrl[v][0]};
            default: return 32'b0;
        endcase
    endfunction

    task automatic chk(int v, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s lock=%0d %s addr=%h actual=%h expected=%h", phase, v, what, addr, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(0, "rdata", rd0, m_rd(0, addr));
            chk(1, "rdata", rd1, m_rd(1, addr));
            chk(0, "irq (R8)", {31'b0, irq0}, {31'b0, m_raw[0] & m_ctrl[0][0]});
            chk(1, "irq (R8)", {31'b0, irq1}, {31'b0, m_raw[1] & m_ctrl[1][0]});
            chk(0, "rst_req (R9)", {31'b0, rq0}, {31'b0, m_rst[0]});
            chk(1, "rst_req (R9)", {31'b0, rq1}, {31'b0, m_rst[1]});
        end
    end

    task automatic cyc(bit w, logic [7:0] a, logic [31:0] d);
        @(posedge clk);
        #2;
        cyc_n++;
        wr_en = w; addr = a; wdata = d;
        tick_en = (tick_every == 1) ? 1'b1 : ((cyc_n % tick_every) == 0);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        cyc(1'b1, a, d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'((i % 7) * 4), 32'h0);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #2;
        rst_n = 0; wr_en = 0;
        repeat (2) @(posedge clk);
        #2;
        rst_n = 1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog expired in phase %s", phase);
        finish_run();
    end

    initial begin
        do_reset();
        phase = "R1";  idle(21);                                   // defaults, no counting
        phase = "R2";  wr(8'h08, 32'hFFFF_FFFC); idle(7);          // only bits [1:0] kept
                       wr(8'h18, 32'd123); wr(8'h10, 32'd1); wr(8'h04, 32'd7); idle(14);
        phase = "R5";  wr(8'h00, 32'd40); idle(14);                // load sets value, no start
        phase = "R3";  wr(8'h08, 32'd1); idle(10);                 // run
                       wr(8'h08, 32'd0); idle(10);                 // freeze (unlocked copy)
        phase = "R4";  wr(8'h08, 32'd1); idle(5);                  // 0->1 reload
                       wr(8'h08, 32'd1); idle(5);                  // unchanged: no reload
        phase = "R6";  idle(60);                                   // zero hit and reload
        phase = "R8";  idle(14);
        phase = "R7";  wr(8'h0C, 32'hDEAD_BEEF); idle(7);
        phase = "R9";  wr(8'h00, 32'd6); wr(8'h08, 32'd3); idle(30);
                       wr(8'h0C, 32'd0); idle(7);                  // request stays up
        phase = "R11"; tick_every = 3; wr(8'h00, 32'd9); idle(20);
                       wr(8'h08, 32'd0); wr(8'h08, 32'd1); idle(20);
                       wr(8'h00, 32'd4); wr(8'h0C, 32'd0); idle(20); tick_every = 1;
        phase = "R10"; do_reset(); wr(8'h00, 32'd15); wr(8'h08, 32'd1);
                       wr(8'h08, 32'd0); idle(10); wr(8'h08, 32'd2); idle(40);
        phase = "R1";  do_reset(); idle(14);
        finish_run();
    end
endmodule